// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's complement operands of width `N` over several clock cycles. It uses radix-2 Booth recoding. A one-cycle `start` pulse loads the operands and sets `busy`. In each of the next `N` cycles, the block looks at the lowest multiplier bit together with a trailing history bit. From that pair it adds the multiplicand to the accumulator, subtracts it, or does neither. It then shifts the chain {accumulator, multiplier register, history bit} right by one place, and the sign of the accumulator is copied into its top bit.

When the last iteration finishes, `busy` drops and `done` pulses for one cycle. The `2N`-bit product then appears as the accumulator's low half followed by the multiplier register. No sign correction step is needed afterwards. The product holds until the next accepted start.

After every iteration, `stepValid` pulses and three observation outputs show the register contents, so each step of the recoding can be followed. The accumulator has one guard bit inside the block. This keeps the product exact even when the multiplicand is the most negative value.

Top module: `booth_radix2_mul`

## Requirements
- R1: A `start` seen while `busy` is low is accepted. On the next cycle `busy` is high, `stepAcc` is 0, `stepQPrev` is 0 and `stepQ` equals the `multiplier` that was sampled.
- R2: An accepted start causes exactly `N` iterations, one per clock cycle. In the cycle after the last iteration, `done` is high for exactly one cycle and `busy` is low. The start edge plus `N` edges takes `done` high.
- R3: When the pair {Q bit 0, history bit} is 00 or 11, the accumulator is left unchanged before the shift.
- R4: When the pair is 01, the multiplicand is added to the accumulator before the shift.
- R5: When the pair is 10, the multiplicand is subtracted from the accumulator before the shift.
- R6: The shift moves the chain right by one as a single unit. The accumulator's sign bit is kept, accumulator bit 0 enters Q bit `N-1`, and Q bit 0 enters the history bit. With N=4, M=0011 and Q=1100, the A/Q/history values are 0000/0110/0, 0000/0011/0, 1110/1001/1 and 1111/0100/1 after steps 1 to 4.
- R7: After `done`, `product` equals the signed product of the two operands, written as {accumulator[N-1:0], Q}. This holds for every operand pair, including the most negative values.
- R8: A `start` raised while `busy` is high is ignored. The iteration in progress goes on and its result is unchanged.
- R9: While `busy` is low and no start is accepted, `product` stays stable, whatever the operand inputs do.
- R10: `stepValid` is high for one cycle after each iteration. At that time `stepAcc`, `stepQ` and `stepQPrev` show the accumulator low half, the Q register and the history bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a multiplication |
| multiplicand | input | N | Signed multiplicand, sampled on accepted start |
| multiplier | input | N | Signed multiplier, sampled on accepted start |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse after the last iteration |
| product | output | 2N | Signed product {accumulator low half, Q} |
| stepValid | output | 1 | Pulse after each iteration |
| stepAcc | output | N | Accumulator low half |
| stepQ | output | N | Multiplier register |
| stepQPrev | output | 1 | History bit |

## Verification
The bench builds the block with N=4. At that width all 256 operand pairs can be swept in full. The sweep covers both most negative operands, every recoding pair at every step position, and long runs of ones and zeros. A behavioural model follows every clock of every multiplication. The model also checks the published 3 by -4 step sequence, a start raised during an operation, and operand changes while the block is idle.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } boothCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } boothState_e;
endpackage

// File: rtl/booth_control.sv
module booth_control
  import booth_pkg::*;
#(
  parameter int N = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output boothCtrl_t ctrl,
  output logic       busy,
  output logic       done,
  output logic       stepValid
);
  localparam int CNT_W = $clog2(N + 1);

  boothState_e       state;
  logic [CNT_W-1:0]  iterLeft;
  logic              doneR;
  logic              stepR;

  always_comb begin
    ctrl.load = (state == ST_IDLE) && start;
    ctrl.step = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      iterLeft <= '0;
      doneR    <= 1'b0;
      stepR    <= 1'b0;
    end else begin
      doneR <= 1'b0;
      stepR <= ctrl.step;
      case (state)
        ST_IDLE: begin
          if (start) begin
            iterLeft <= CNT_W'(N);
            state    <= ST_RUN;
          end
        end
        default: begin
          iterLeft <= iterLeft - 1'b1;
          if (iterLeft == CNT_W'(1)) begin
            state <= ST_IDLE;
            doneR <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy      = (state == ST_RUN);
  assign done      = doneR;
  assign stepValid = stepR;
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  boothCtrl_t   ctrl,
  input  logic [N-1:0] multiplicand,
  input  logic [N-1:0] multiplier,
  output logic [N-1:0] accLow,
  output logic [N-1:0] mulReg,
  output logic         histBit
);
  // One guard bit keeps A +/- M exact for the most negative operand
  localparam int ACC_W = N + 1;

  logic [ACC_W-1:0] accReg;
  logic [ACC_W-1:0] mcandExt;
  logic [ACC_W-1:0] accNext;
  logic [N-1:0]     qReg;
  logic             qPrev;

  always_comb begin
    case ({qReg[0], qPrev})
      2'b01:   accNext = accReg + mcandExt;
      2'b10:   accNext = accReg - mcandExt;
      default: accNext = accReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg   <= '0;
      mcandExt <= '0;
      qReg     <= '0;
      qPrev    <= 1'b0;
    end else if (ctrl.load) begin
      accReg   <= '0;
      mcandExt <= {multiplicand[N-1], multiplicand};
      qReg     <= multiplier;
      qPrev    <= 1'b0;
    end else if (ctrl.step) begin
      accReg <= {accNext[ACC_W-1], accNext[ACC_W-1:1]};
      qReg   <= {accNext[0], qReg[N-1:1]};
      qPrev  <= qReg[0];
    end
  end

  assign accLow  = accReg[N-1:0];
  assign mulReg  = qReg;
  assign histBit = qPrev;
endmodule

// File: rtl/booth_radix2_mul.sv
module booth_radix2_mul
  import booth_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product,
  output logic           stepValid,
  output logic [N-1:0]   stepAcc,
  output logic [N-1:0]   stepQ,
  output logic           stepQPrev
);
  boothCtrl_t ctrl;

  booth_control #(.N(N)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .ctrl      (ctrl),
    .busy      (busy),
    .done      (done),
    .stepValid (stepValid)
  );

  booth_datapath #(.N(N)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .accLow       (stepAcc),
    .mulReg       (stepQ),
    .histBit      (stepQPrev)
  );

  assign product = {stepAcc, stepQ};
endmodule

// File: rtl/booth_mul_checker.sv
module booth_mul_checker #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic [N-1:0]   multiplicand,
  input logic [N-1:0]   multiplier,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product,
  input logic           stepValid,
  input logic [N-1:0]   stepAcc,
  input logic [N-1:0]   stepQ,
  input logic           stepQPrev
);
  // Busy-cycle counter so the N window is checked without deep $past
  int busyCycles;
  always_ff @(posedge clk) begin
    if (!rstN) busyCycles <= 0;
    else if (start && !busy) busyCycles <= 0;
    else if (busy) busyCycles <= busyCycles + 1;
  end

  p_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && stepAcc == '0 && !stepQPrev && stepQ == $past(multiplier)));

  p_done_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && busyCycles == N));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_skip_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && $past(stepQ[0]) == $past(stepQPrev)) |-> (stepAcc[N-2:0] == $past(stepAcc[N-1:1])));

  p_shift_chain_r6: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |-> (stepQPrev == $past(stepQ[0]) && stepQ[N-2:0] == $past(stepQ[N-1:1])));

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (stepValid && stepQPrev == $past(stepQ[0])));

  p_hold_product_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));

  p_step_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> stepValid);
endmodule

bind booth_radix2_mul booth_mul_checker #(.N(N)) u_chk (.*);

// File: tb/booth_radix2_mul_tb.sv
module booth_radix2_mul_tb;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   multiplicand = '0;
  logic [N-1:0]   multiplier = '0;
  logic           busy, done, stepValid, stepQPrev;
  logic [2*N-1:0] product;
  logic [N-1:0]   stepAcc, stepQ;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  booth_radix2_mul #(.N(N)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .busy(busy), .done(done), .product(product),
    .stepValid(stepValid), .stepAcc(stepAcc), .stepQ(stepQ), .stepQPrev(stepQPrev)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Behavioural model: exact integers, one iteration per clock
  task automatic run_mul(input int a, input int b, input bit pokeStart, input bit idleWiggle);
    int accM, qM, hM, pairV, expProd;
    string opTag;
    logic [2*N-1:0] held;
    accM = 0;
    qM = b & ((1 << N) - 1);
    hM = 0;
    @(negedge clk);
    multiplicand = N'(a);
    multiplier   = N'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    multiplicand = ~multiplicand;
    multiplier   = ~multiplier;
    check(busy === 1'b1, "R1 busy", busy, 1);
    check(stepAcc === '0 && stepQPrev === 1'b0, "R1 clear", {stepAcc, stepQPrev}, 0);
    check(stepQ === N'(qM), "R1 load Q", stepQ, qM);
    for (int i = 0; i < N; i++) begin
      pairV = ((qM & 1) << 1) | hM;
      if (pairV == 1) begin accM = accM + a; opTag = "R4 add"; end
      else if (pairV == 2) begin accM = accM - a; opTag = "R5 sub"; end
      else opTag = "R3 skip";
      hM   = qM & 1;
      qM   = (qM >> 1) | ((accM & 1) << (N - 1));
      accM = accM >>> 1;
      if (pokeStart && i == 1) start = 1'b1;  // R8: start while busy
      @(negedge clk);
      start = 1'b0;
      check(stepValid === 1'b1, "R10 stepValid", stepValid, 1);
      check(stepAcc === N'(accM), opTag, stepAcc, accM & ((1 << N) - 1));
      check(stepQ === N'(qM), "R6 Q shift", stepQ, qM);
      check(stepQPrev === hM[0], "R6 history", stepQPrev, hM);
      check(done === (i == N - 1), "R2 done timing", done, i == N - 1);
      check(busy === (i != N - 1), "R2 busy timing", busy, i != N - 1);
    end
    expProd = a * b;
    check(product === (2*N)'(expProd), pokeStart ? "R8 product" : "R7 product",
          product, expProd & ((1 << (2*N)) - 1));
    held = product;
    @(negedge clk);
    check(done === 1'b0 && stepValid === 1'b0, "R2 done pulse", {done, stepValid}, 0);
    if (idleWiggle) begin
      for (int k = 0; k < 3; k++) begin
        multiplicand = N'(k * 5 + 3);
        multiplier   = N'(k * 3 + 1);
        @(negedge clk);
        check(product === held, "R9 hold", product, held);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && stepValid === 1'b0, "R2 reset flags",
          {busy, done, stepValid}, 0);
    check(product === '0, "R7 reset product", product, 0);

    // R6 worked case: 3 x -4 -> 11110100
    run_mul(3, -4, 1'b0, 1'b1);
    check(product === 8'hF4, "R6 worked product", product, 8'hF4);

    // Most negative operands
    run_mul(-8, -8, 1'b0, 1'b0);
    run_mul(-8, 7, 1'b0, 1'b1);
    run_mul(-8, 1, 1'b0, 1'b0);

    // R8 start during operation
    run_mul(5, -3, 1'b1, 1'b0);
    run_mul(-7, 6, 1'b1, 1'b1);

    // Exhaustive sweep, R7
    for (int a = -(1 << (N - 1)); a < (1 << (N - 1)); a++)
      for (int b = -(1 << (N - 1)); b < (1 << (N - 1)); b++)
        run_mul(a, b, 1'b0, 1'b0);

    finish_run();
  end
endmodule